// File: doc/BRIEF.md
# Timer Output Compare Unit

An 8-bit timer with a single output compare channel. A counter advances on each cycle in which the timer clock enable is high. It is compared against a live compare value. On a match the block sets a sticky match flag and acts on a waveform output register. Four waveform modes are selected on a 2-bit input: plain up-counting, clear-on-match, fast PWM and phase-correct PWM. The output action is selected on a separate 2-bit input, which is applied as soon as it changes.

A CPU controls the block through simple write strobes. It can write the counter, write the compare value, pulse a forced compare and clear the flag. In the two PWM modes a compare write lands in a shadow register. The shadow register is copied to the live compare value at the top of the count, so a period never sees a half-updated threshold. In the other two modes the write lands directly in the live compare value. Any counter write suppresses the compare on the next enabled timer tick. This lets software preload the counter with the compare value without a spurious match.

Top module: `cmp_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), count, cmp_live, match_flag and wave_out are all 0, and the counter direction is upward.
- R2: In wg_mode 00 (normal), each cycle with tick_en high adds one to count, wrapping from 0xFF to 0x00. A cycle with tick_en low and no counter write leaves count unchanged.
- R3: A real match is an enabled tick, with no counter write in that cycle and no pending block, in which count equals cmp_live. A real match sets match_flag. In modes 00 and 01, the match applies out_mode to wave_out: 00 holds, 01 toggles, 10 drives 0, 11 drives 1. flag_clr clears match_flag unless a match occurs in the same cycle.
- R4: In wg_mode 01 (clear on match), the tick that finds a real match loads count with 0 instead of incrementing it.
- R5: In wg_mode 00 and 01, a cmp_we cycle loads cmp_wdata straight into cmp_live at that edge.
- R6: In wg_mode 10 and 11, cmp_we writes only the shadow register, and cmp_live keeps its value. The shadow is copied into cmp_live on the tick at which count is 0xFF. In mode 11 this copy happens only while counting up.
- R7: In wg_mode 00 and 01, force_stb applies out_mode to wave_out exactly as a match would. It leaves match_flag and count unchanged.
- R8: In wg_mode 10 and 11, force_stb has no effect on wave_out.
- R9: A cnt_we cycle loads cnt_wdata and arms a block. The block suppresses any match, and any clear-on-match, on the next enabled tick. While tick_en stays low the block stays armed.
- R10: A change on out_mode governs the output action in the same cycle it is presented.
- R11: In wg_mode 10 (fast PWM), out_mode 10 sets wave_out on the wrap tick at 0xFF and clears it on a match. out_mode 11 does the opposite.
- R12: In wg_mode 11 (phase-correct PWM), count climbs to 0xFF, then steps down to 0x00, then climbs again; each end value is held for one tick. With out_mode 10, a match clears wave_out while counting up and sets it while counting down. out_mode 11 does the opposite.
- R13: wave_out keeps its value when wg_mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer clock enable; the counter moves only when high |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value write data |
| wg_mode | input | 2 | Waveform mode: 00 normal, 01 clear on match, 10 fast PWM, 11 phase-correct PWM |
| out_mode | input | 2 | Output action select |
| force_stb | input | 1 | Forced compare strobe |
| flag_clr | input | 1 | Clears match_flag |
| count | output | 8 | Current counter value |
| cmp_live | output | 8 | Live compare value used by the comparator |
| match_flag | output | 1 | Sticky compare match flag |
| wave_out | output | 1 | Waveform output register |

## Verification
The hardest state to reach is a block armed by a counter write that must outlive several cycles with the timer clock stopped. In the same situation the counter sits exactly on the compare value, so the first enabled tick would otherwise match. The stimulus writes the counter with the compare value in clear-on-match mode and holds tick_en low for two cycles. It then issues one tick and expects no flag, no output action and no clear to zero. A second hard case is the shadow copy at the top of a phase-correct sweep. The stimulus preloads the counter just below 0xFF, so the reversal and the copy happen within a few cycles instead of a full period.

// File: rtl/cmp_timer_pkg.sv
// Shared encodings for the timer output compare unit.
// Assumes a 2-bit waveform mode and a 2-bit output action select.
package cmp_timer_pkg;

    typedef enum logic [1:0] {
        WG_NORMAL = 2'b00,
        WG_CTC    = 2'b01,
        WG_FAST   = 2'b10,
        WG_PHASE  = 2'b11
    } wg_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } out_act_e;

    // True for both PWM modes, which share the upper mode bit.
    function automatic logic is_pwm(input wg_mode_e m);
        return m[1];
    endfunction

    // Next output level for a non-PWM compare event.
    function automatic logic apply_act(input out_act_e a, input logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/cmp_timer_counter.sv
// Counter and direction logic.
// Counts on tick_en, and a CPU write takes priority over a tick.
// Derives the top-of-sequence event used for shadow copies and fast PWM wrap.
// Assumes match_hit is already qualified by blocking and tick_en.
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  wg_mode_e     mode,
    input  logic         match_hit,
    output logic [W-1:0] count,
    output logic         count_up,
    output logic         top_evt
);
    localparam logic [W-1:0] CNT_MAX  = {W{1'b1}};
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, cnt_d;
    logic         up_q, up_d;
    logic         adv;

    assign adv = tick_en && !cnt_we;

    // Top of sequence: 0xFF in every mode, and only while rising in phase-correct.
    assign top_evt = adv && (cnt_q == CNT_MAX) && (mode != WG_PHASE || up_q);

    // Next counter value and direction.
    always_comb begin
        cnt_d = cnt_q;
        up_d  = up_q;
        if (cnt_we) begin
            cnt_d = cnt_wdata;
        end else if (tick_en) begin
            case (mode)
                WG_CTC: cnt_d = match_hit ? CNT_ZERO : cnt_q + CNT_ONE;
                WG_PHASE: begin
                    if (up_q) begin
                        if (cnt_q == CNT_MAX) begin
                            cnt_d = CNT_MAX - CNT_ONE;
                            up_d  = 1'b0;
                        end else begin
                            cnt_d = cnt_q + CNT_ONE;
                        end
                    end else begin
                        if (cnt_q == CNT_ZERO) begin
                            cnt_d = CNT_ONE;
                            up_d  = 1'b1;
                        end else begin
                            cnt_d = cnt_q - CNT_ONE;
                        end
                    end
                end
                default: cnt_d = cnt_q + CNT_ONE;
            endcase
        end
        if (mode != WG_PHASE) up_d = 1'b1;
    end

    // Counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    assign count    = cnt_q;
    assign count_up = up_q;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_we) |=> $stable(cnt_q));

    // R4
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_CTC && match_hit && !cnt_we) |=> (cnt_q == CNT_ZERO));

endmodule

// File: rtl/cmp_timer_compare.sv
// Compare value storage and match detection.
// Holds the shadow register and the live compare value, plus the block armed by counter writes.
// Assumes top_evt comes from the counter and is already gated by tick_en.
module cmp_timer_compare
    import cmp_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wg_mode_e     mode,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         cnt_we,
    input  logic         tick_en,
    input  logic [W-1:0] count,
    input  logic         top_evt,
    output logic [W-1:0] cmp_live,
    output logic         match_hit
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] live_q;
    logic         block_q;
    logic         pwm;

    assign pwm = is_pwm(mode);

    // Shadow register always tracks CPU compare writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_q <= '0;
        else if (cmp_we) shadow_q <= cmp_wdata;
    end

    // Live compare value: direct write outside PWM, copy from shadow at top in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)                live_q <= '0;
        else if (!pwm && cmp_we)   live_q <= cmp_wdata;
        else if (pwm && top_evt)   live_q <= shadow_q;
    end

    // Block armed by a counter write, released by the next enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       block_q <= 1'b0;
        else if (cnt_we)  block_q <= 1'b1;
        else if (tick_en) block_q <= 1'b0;
    end

    assign match_hit = tick_en && !cnt_we && !block_q && (count == live_q);
    assign cmp_live  = live_q;

    // R9
    block_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !tick_en) |=> !match_hit);

    // R9
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_q && !tick_en && !cnt_we) |=> block_q);

    // R5
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && cmp_we) |=> (live_q == $past(cmp_wdata)));

    // R6
    shadow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !top_evt) |=> $stable(live_q));

endmodule

// File: rtl/cmp_timer_wave.sv
// Waveform output register.
// Applies the selected output action on matches, forced compares and the fast PWM wrap.
// Assumes count_up reflects the direction of the count value being compared.
module cmp_timer_wave
    import cmp_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wg_mode_e mode,
    input  out_act_e act,
    input  logic     match_hit,
    input  logic     force_stb,
    input  logic     top_evt,
    input  logic     count_up,
    output logic     wave
);
    logic wave_q, wave_d;

    // Output action per mode; in fast PWM a match overrides the wrap action.
    always_comb begin
        wave_d = wave_q;
        case (mode)
            WG_FAST: begin
                if (top_evt) begin
                    if (act == ACT_LOW)  wave_d = 1'b1;
                    if (act == ACT_HIGH) wave_d = 1'b0;
                end
                if (match_hit) begin
                    if (act == ACT_LOW)  wave_d = 1'b0;
                    if (act == ACT_HIGH) wave_d = 1'b1;
                end
            end
            WG_PHASE: begin
                if (match_hit) begin
                    if (act == ACT_LOW)  wave_d = !count_up;
                    if (act == ACT_HIGH) wave_d = count_up;
                end
            end
            default: begin
                if (match_hit || force_stb) wave_d = apply_act(act, wave_q);
            end
        endcase
    end

    // Output register; unaffected by mode changes.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign wave = wave_q;

    // R8
    force_ignored_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(mode) && force_stb && !match_hit && !top_evt) |=> $stable(wave_q));

    // R3
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pwm(mode) && act == ACT_TOGGLE && match_hit) |=> (wave_q != $past(wave_q)));

    // R11
    fast_wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_FAST && act == ACT_LOW && top_evt && !match_hit) |=> wave_q);

endmodule

// File: rtl/cmp_timer.sv
// Top of the timer output compare unit.
// Wires counter, compare and waveform stages and keeps the sticky match flag.
// Assumes all CPU strobes are single-cycle and synchronous to clk.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic [1:0]   wg_mode,
    input  logic [1:0]   out_mode,
    input  logic         force_stb,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic [W-1:0] cmp_live,
    output logic         match_flag,
    output logic         wave_out
);
    wg_mode_e     mode;
    out_act_e     act;
    logic         match_hit;
    logic         top_evt;
    logic         count_up;
    logic         flag_q;
    logic [W-1:0] cnt_val;
    logic [W-1:0] live_val;

    assign mode = wg_mode_e'(wg_mode);
    assign act  = out_act_e'(out_mode);

    cmp_timer_counter #(.W(W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .mode      (mode),
        .match_hit (match_hit),
        .count     (cnt_val),
        .count_up  (count_up),
        .top_evt   (top_evt)
    );

    cmp_timer_compare #(.W(W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .cnt_we    (cnt_we),
        .tick_en   (tick_en),
        .count     (cnt_val),
        .top_evt   (top_evt),
        .cmp_live  (live_val),
        .match_hit (match_hit)
    );

    cmp_timer_wave u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .act       (act),
        .match_hit (match_hit),
        .force_stb (force_stb),
        .top_evt   (top_evt),
        .count_up  (count_up),
        .wave      (wave_out)
    );

    // Sticky match flag: set by a real match, cleared by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (match_hit) flag_q <= 1'b1;
        else if (flag_clr)  flag_q <= 1'b0;
    end

    assign count      = cnt_val;
    assign cmp_live   = live_val;
    assign match_flag = flag_q;

    // R7
    force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !match_hit && !flag_q) |=> !flag_q);

    // R3
    flag_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> flag_q);

endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

    typedef struct packed {
        logic       cw;
        logic       ow;
        logic       fs;
        logic       tk;
        logic       fc;
        logic [7:0] d;
        logic [1:0] md;
        logic [1:0] cm;
        logic [7:0] ec;
        logic [7:0] eo;
        logic       ef;
        logic       ex;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 27;
    // Fields: cw ow fs tk fc data mode act | exp count, exp cmp_live, exp flag, exp wave, requirement
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,2'd0,2'd0, 8'h00,8'h03,1'b0,1'b0, 4'd5},  // R5 direct write
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h03,2'd0,2'd0, 8'h03,8'h03,1'b0,1'b0, 4'd9},  // R9 preload = compare
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd0,2'd1, 8'h04,8'h03,1'b0,1'b0, 4'd9},  // R9 blocked match
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h02,2'd0,2'd1, 8'h02,8'h03,1'b0,1'b0, 4'd2},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd0,2'd1, 8'h03,8'h03,1'b0,1'b0, 4'd2},  // R2 count
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd0,2'd1, 8'h04,8'h03,1'b1,1'b1, 4'd3},  // R3 toggle
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,2'd0,2'd1, 8'h04,8'h03,1'b0,1'b1, 4'd3},  // R3 clear flag
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,2'd0,2'd2, 8'h04,8'h03,1'b0,1'b0, 4'd7},  // R7 R10 force low
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,2'd0,2'd3, 8'h04,8'h03,1'b0,1'b1, 4'd10}, // R10 force high
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,2'd0,2'd1, 8'h04,8'h03,1'b0,1'b0, 4'd7},  // R7 force toggle
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h02,2'd1,2'd3, 8'h02,8'h03,1'b0,1'b0, 4'd13}, // R13 mode change
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd1,2'd3, 8'h03,8'h03,1'b0,1'b0, 4'd9},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd1,2'd3, 8'h00,8'h03,1'b1,1'b1, 4'd4},  // R4 clear to zero
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd1,2'd2, 8'h01,8'h03,1'b1,1'b1, 4'd4},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,2'd1,2'd2, 8'h02,8'h03,1'b1,1'b0, 4'd7},  // R7 force keeps count
        '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h03,2'd1,2'd1, 8'h03,8'h03,1'b0,1'b0, 4'd9},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,2'd1, 8'h03,8'h03,1'b0,1'b0, 4'd2},  // R2 hold
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,2'd1, 8'h03,8'h03,1'b0,1'b0, 4'd9},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd1,2'd1, 8'h04,8'h03,1'b0,1'b0, 4'd9},  // R9 stopped clock
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h10,2'd2,2'd0, 8'h04,8'h03,1'b0,1'b0, 4'd6},  // R6 shadow only
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'hFE,2'd2,2'd0, 8'hFE,8'h03,1'b0,1'b0, 4'd6},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd2,2'd0, 8'hFF,8'h03,1'b0,1'b0, 4'd6},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd2,2'd2, 8'h00,8'h10,1'b0,1'b1, 4'd11}, // R11 R6 wrap
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,2'd2,2'd2, 8'h00,8'h10,1'b0,1'b1, 4'd8},  // R8 force ignored
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h0F,2'd2,2'd2, 8'h0F,8'h10,1'b0,1'b1, 4'd11},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd2,2'd2, 8'h10,8'h10,1'b0,1'b1, 4'd11},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,2'd2,2'd2, 8'h11,8'h10,1'b1,1'b0, 4'd11}  // R11 clear on match
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0, force_stb = 1'b0, flag_clr = 1'b0;
    logic [7:0] cnt_wdata = '0, cmp_wdata = '0;
    logic [1:0] wg_mode = '0, out_mode = '0;
    logic [7:0] count, cmp_live;
    logic       match_flag, wave_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_timer u_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .wg_mode(wg_mode), .out_mode(out_mode),
        .force_stb(force_stb), .flag_clr(flag_clr), .count(count), .cmp_live(cmp_live),
        .match_flag(match_flag), .wave_out(wave_out)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic cw, input logic ow, input logic fs, input logic tk, input logic fc,
                        input logic [7:0] d, input logic [1:0] md, input logic [1:0] cm);
        @(negedge clk);
        cnt_we = cw; cmp_we = ow; force_stb = fs; tick_en = tk; flag_clr = fc;
        cnt_wdata = d; cmp_wdata = d; wg_mode = md; out_mode = cm;
        @(posedge clk);
        #1;
        cnt_we = 1'b0; cmp_we = 1'b0; force_stb = 1'b0; tick_en = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        string rq;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "count", count, 8'h00);
        chk("R1", "cmp_live", cmp_live, 8'h00);
        chk("R1", "flag", {7'd0, match_flag}, 8'h00);
        chk("R1", "wave", {7'd0, wave_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].cw, TBL[i].ow, TBL[i].fs, TBL[i].tk, TBL[i].fc, TBL[i].d, TBL[i].md, TBL[i].cm);
            rq = $sformatf("R%0d row %0d", TBL[i].rq, i);
            chk(rq, "count", count, TBL[i].ec);
            chk(rq, "cmp_live", cmp_live, TBL[i].eo);
            chk(rq, "flag", {7'd0, match_flag}, {7'd0, TBL[i].ef});
            chk(rq, "wave", {7'd0, wave_out}, {7'd0, TBL[i].ex});
        end

        // R6 phase-correct: shadow write, copy at top while rising
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 2'd3, 2'd0);
        chk("R6", "cmp_live kept", cmp_live, 8'h10);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFE, 2'd3, 2'd0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd3, 2'd0);
        chk("R12", "count rising", count, 8'hFF);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd3, 2'd0);
        chk("R12", "count reversed", count, 8'hFE);
        chk("R6", "cmp_live copied at top", cmp_live, 8'h80);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd3, 2'd0);
        chk("R12", "count falling", count, 8'hFD);
        // R12 down-count match with act 10 sets the output
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 2'd3, 2'd2);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd3, 2'd2);
        chk("R12", "wave before match", {7'd0, wave_out}, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd3, 2'd2);
        chk("R12", "wave set falling", {7'd0, wave_out}, 8'h01);
        chk("R12", "count after match", count, 8'h7F);
        chk("R3", "flag on pwm match", {7'd0, match_flag}, 8'h01);
        // R12 reversal at bottom
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 2'd3, 2'd0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd3, 2'd0);
        chk("R12", "count bottom", count, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd3, 2'd0);
        chk("R12", "count climbs", count, 8'h01);
        // R13 output kept across mode change
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0);
        chk("R13", "wave kept", {7'd0, wave_out}, 8'h01);
        chk("R2", "count normal", count, 8'h02);
        // R2 wrap
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'd0, 2'd0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0);
        chk("R2", "wrap", count, 8'h00);
        // R1 reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "count after reset", count, 8'h00);
        chk("R1", "wave after reset", {7'd0, wave_out}, 8'h00);
        chk("R1", "flag after reset", {7'd0, match_flag}, 8'h00);
        chk("R1", "cmp_live after reset", cmp_live, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule